// File: doc/BRIEF.md
# Receive-Clock Rate Guard

This block watches the receive clock of one repeater port from the reference clock domain and decides whether that clock runs at the 100 Mb/s rate (25 MHz) or the 10 Mb/s rate (10 MHz). It brings rising edges of the receive clock through a two-flop synchroniser. It counts them over a fixed window of reference cycles and sorts the count into a fast band, a slow band or "no valid clock". The result drives a detected-speed status bit. That bit changes only after two consecutive windows agree.

The detected speed is compared with the speed-select input. A difference raises a mismatch flag. When the isolate-enable configuration bit is set, the mismatch also cuts the port off from the repeater. Any change of the speed-select input starts a fixed-length reset pulse for the port's core logic. While that pulse is high, the measurement restarts from zero. Mismatch reporting then stays quiet until one full window has finished.

The speed-select and isolate-enable inputs are taken to be synchronous to the reference clock. The receive clock is fully asynchronous.

Top module: `rate_guard`

## Requirements
- R1: Receive-clock rising edges pass through a two-flop synchroniser and are counted over windows of WIN_CYCLES reference cycles. A window count within FAST_CNT±TOL is classed as fast (100 Mb/s), a count within SLOW_CNT±TOL as slow (10 Mb/s), and any other count as no valid clock.
- R2: `ds` is 1 for fast and 0 for slow. It takes a new value only when two consecutive windows give the same valid class.
- R3: When `speed_sel` differs from its value sampled at the previous reference edge, `core_rst` goes high from the next edge for exactly RST_CYCLES reference cycles. A further change during the pulse restarts the pulse.
- R4: While `core_rst` is high, the window and edge counters are held at zero, the two-window agreement history is cleared and `ds` keeps its value.
- R5: `mismatch` is 1 when `ds` differs from `speed_sel` (1 = 100 Mb/s, 0 = 10 Mb/s). Two further conditions apply: `ds` must have been set by at least one agreeing pair of windows since reset, and one full window must have completed since `core_rst` last fell. `mismatch` is 0 while `core_rst` is high.
- R6: `isolate` is 1 exactly when `mismatch` and `iso_en` are both 1, in the same cycle. With `iso_en` at 0 it never rises. It falls in the same cycle as `mismatch`.
- R7: After the synchronous reset `rst`, `ds`, `mismatch`, `isolate` and `core_rst` are all 0.
- R8: Windows classed as no valid clock (for example a stopped receive clock) leave `ds` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk | input | 1 | Port receive clock, asynchronous, sampled as data |
| speed_sel | input | 1 | Selected speed: 1 = 100 Mb/s, 0 = 10 Mb/s |
| iso_en | input | 1 | Allow isolation of the port on a speed mismatch |
| ds | output | 1 | Detected speed: 1 = 100 Mb/s, 0 = 10 Mb/s |
| mismatch | output | 1 | Detected and selected speeds differ |
| isolate | output | 1 | Cut the port off from the repeater |
| core_rst | output | 1 | Reset pulse for the port core after a speed-select change |

## Verification
`core_rst` rises at the first reference edge after `speed_sel` changes and stays high for RST_CYCLES samples. The bench reads it at every falling edge across that span. The window counter starts at the edge where `core_rst` falls. The first classification becomes visible about WIN_CYCLES+1 cycles later, and a `ds` update about 2·WIN_CYCLES+1 cycles later. Checks are therefore placed a few cycles before and after each of these points, never on them. This separates the two-window filter from a one-window update. `isolate` is combinational from `mismatch` and `iso_en`, so it is checked at the falling edge right after `iso_en` is driven.

// File: rtl/rate_guard_pkg.sv
package rate_guard_pkg;

    typedef enum logic [1:0] {
        RATE_NONE = 2'd0,
        RATE_10   = 2'd1,
        RATE_100  = 2'd2
    } rate_e;

    typedef struct packed {
        logic  vld;
        rate_e rate;
    } meas_t;

    function automatic logic in_band(input int unsigned n,
                                     input int unsigned centre,
                                     input int unsigned tol);
        return (n + tol >= centre) && (n <= centre + tol);
    endfunction

    function automatic rate_e classify_count(input int unsigned n,
                                             input int unsigned fast_n,
                                             input int unsigned slow_n,
                                             input int unsigned tol);
        if (in_band(n, fast_n, tol))
            return RATE_100;
        else if (in_band(n, slow_n, tol))
            return RATE_10;
        else
            return RATE_NONE;
    endfunction

endpackage

// File: rtl/rg_edge_sync.sv
module rg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rg_meter.sv
module rg_meter
    import rate_guard_pkg::*;
#(
    parameter int WIN_CYCLES = 250,
    parameter int FAST_CNT   = 25,
    parameter int SLOW_CNT   = 10,
    parameter int TOL        = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  edge_i,
    output meas_t meas_o
);
    localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic [WW-1:0] win_cnt;
    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] total;
    logic          win_end;
    meas_t         meas_q;

    assign win_end = (win_cnt == WW'(WIN_CYCLES - 1));
    assign total   = edge_cnt + CW'(edge_i);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            meas_q   <= '{vld: 1'b0, rate: RATE_NONE};
        end else begin
            meas_q.vld <= 1'b0;
            if (win_end) begin
                win_cnt     <= '0;
                edge_cnt    <= '0;
                meas_q.vld  <= 1'b1;
                meas_q.rate <= classify_count(32'(total), FAST_CNT, SLOW_CNT, TOL);
            end else begin
                win_cnt  <= win_cnt + WW'(1);
                edge_cnt <= total;
            end
        end
    end

    assign meas_o = meas_q;
endmodule

// File: rtl/rg_select_ctl.sv
module rg_select_ctl #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_in,
    output logic sel_q,
    output logic core_rst
);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    logic [RCW-1:0] rst_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= sel_in;
            rst_cnt <= '0;
        end else if (sel_in != sel_q) begin
            sel_q   <= sel_in;
            rst_cnt <= RCW'(RST_CYCLES);
        end else if (rst_cnt != '0) begin
            rst_cnt <= rst_cnt - RCW'(1);
        end
    end

    assign core_rst = (rst_cnt != '0);
endmodule

// File: rtl/rg_verdict.sv
module rg_verdict
    import rate_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  meas_t meas_i,
    input  logic  sel_q,
    input  logic  iso_en,
    output logic  ds,
    output logic  mismatch,
    output logic  isolate
);
    rate_e prev_rate;
    logic  ds_q;
    logic  ds_known;
    logic  armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ds_q      <= 1'b0;
            ds_known  <= 1'b0;
            prev_rate <= RATE_NONE;
            armed     <= 1'b0;
        end else if (clr) begin
            prev_rate <= RATE_NONE;
            armed     <= 1'b0;
        end else if (meas_i.vld) begin
            armed     <= 1'b1;
            prev_rate <= meas_i.rate;
            if (meas_i.rate != RATE_NONE && meas_i.rate == prev_rate) begin
                ds_q     <= (meas_i.rate == RATE_100);
                ds_known <= 1'b1;
            end
        end
    end

    assign ds       = ds_q;
    assign mismatch = armed & ds_known & ~clr & (ds_q ^ sel_q);
    assign isolate  = mismatch & iso_en;
endmodule

// File: rtl/rate_guard.sv
module rate_guard
    import rate_guard_pkg::*;
#(
    parameter int WIN_CYCLES  = 250,
    parameter int FAST_CNT    = 25,
    parameter int SLOW_CNT    = 10,
    parameter int TOL         = 3,
    parameter int RST_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic rx_clk,
    input  logic speed_sel,
    input  logic iso_en,
    output logic ds,
    output logic mismatch,
    output logic isolate,
    output logic core_rst
);
    logic  rx_rise;
    logic  sel_q;
    meas_t meas;

    rg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .rst      (rst),
        .async_in (rx_clk),
        .rise     (rx_rise)
    );

    rg_select_ctl #(.RST_CYCLES(RST_CYCLES)) u_sel (
        .clk      (clk_ref),
        .rst      (rst),
        .sel_in   (speed_sel),
        .sel_q    (sel_q),
        .core_rst (core_rst)
    );

    rg_meter #(
        .WIN_CYCLES (WIN_CYCLES),
        .FAST_CNT   (FAST_CNT),
        .SLOW_CNT   (SLOW_CNT),
        .TOL        (TOL)
    ) u_meter (
        .clk    (clk_ref),
        .rst    (rst),
        .clr    (core_rst),
        .edge_i (rx_rise),
        .meas_o (meas)
    );

    rg_verdict u_verdict (
        .clk      (clk_ref),
        .rst      (rst),
        .clr      (core_rst),
        .meas_i   (meas),
        .sel_q    (sel_q),
        .iso_en   (iso_en),
        .ds       (ds),
        .mismatch (mismatch),
        .isolate  (isolate)
    );
endmodule

// File: rtl/rate_guard_chk.sv
module rate_guard_chk #(
    parameter int RST_CYCLES = 8
) (
    input logic clk_ref,
    input logic rst,
    input logic speed_sel,
    input logic iso_en,
    input logic ds,
    input logic mismatch,
    input logic isolate,
    input logic core_rst
);
    localparam int LW = $clog2(RST_CYCLES + 2);

    logic          sel_seen;
    logic [LW-1:0] run_len;

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            sel_seen <= speed_sel;
            run_len  <= '0;
        end else begin
            sel_seen <= speed_sel;
            if (speed_sel != sel_seen)
                run_len <= '0;
            else if (core_rst)
                run_len <= run_len + LW'(1);
            else
                run_len <= '0;
        end
    end

    assert_rst_start_R3: assert property (@(posedge clk_ref) disable iff (rst)
        (speed_sel != sel_seen) |=> core_rst);

    assert_rst_length_R3: assert property (@(posedge clk_ref) disable iff (rst)
        $fell(core_rst) |-> (run_len == LW'(RST_CYCLES)));

    assert_rst_bound_R3: assert property (@(posedge clk_ref) disable iff (rst)
        core_rst |-> (run_len < LW'(RST_CYCLES)));

    assert_ds_frozen_R4: assert property (@(posedge clk_ref) disable iff (rst)
        core_rst |=> $stable(ds));

    assert_quiet_in_reset_R5: assert property (@(posedge clk_ref) disable iff (rst)
        core_rst |-> !mismatch);

    assert_mm_polarity_R5: assert property (@(posedge clk_ref) disable iff (rst)
        (mismatch && speed_sel == sel_seen) |-> (ds != speed_sel));

    assert_no_iso_when_off_R6: assert property (@(posedge clk_ref) disable iff (rst)
        !iso_en |-> !isolate);

    assert_iso_needs_mm_R6: assert property (@(posedge clk_ref) disable iff (rst)
        isolate |-> mismatch);
endmodule

bind rate_guard rate_guard_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk_ref   (clk_ref),
    .rst       (rst),
    .speed_sel (speed_sel),
    .iso_en    (iso_en),
    .ds        (ds),
    .mismatch  (mismatch),
    .isolate   (isolate),
    .core_rst  (core_rst)
);

// File: tb/rate_guard_tb.sv
module rate_guard_tb;
    localparam int WIN = 250;
    localparam int RSTN = 8;

    logic clk_ref = 1'b0;
    logic rst = 1'b1;
    logic rx_clk;
    logic speed_sel = 1'b1;
    logic iso_en = 1'b0;
    logic ds, mismatch, isolate, core_rst;
    int   rx_half = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2 clk_ref = ~clk_ref;

    initial begin
        rx_clk = 1'b0;
        forever begin
            if (rx_half == 0) begin
                rx_clk = 1'b0;
                #4;
            end else begin
                #(rx_half) rx_clk = ~rx_clk;
            end
        end
    end

    rate_guard #(.WIN_CYCLES(WIN), .RST_CYCLES(RSTN)) u_dut (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .rx_clk    (rx_clk),
        .speed_sel (speed_sel),
        .iso_en    (iso_en),
        .ds        (ds),
        .mismatch  (mismatch),
        .isolate   (isolate),
        .core_rst  (core_rst)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // R7: reset state
    task automatic t_reset();
        rst = 1'b1;
        cyc(5);
        rst = 1'b0;
        cyc(1);
        chk("R7 ds", ds, 1'b0);
        chk("R7 mismatch", mismatch, 1'b0);
        chk("R7 isolate", isolate, 1'b0);
        chk("R7 core_rst", core_rst, 1'b0);
    endtask

    // R1/R2: fast clock with matching select locks ds to 1
    task automatic t_fast_lock();
        rx_half = 20;
        cyc(3 * WIN + 20);
        chk("R1 fast ds", ds, 1'b1);
        chk("R5 no mismatch when equal", mismatch, 1'b0);
    endtask

    // R3/R4/R5/R6/R2: select change, reset pulse, armed delay, filter
    task automatic t_sel_change();
        speed_sel = 1'b0;
        for (int i = 0; i < RSTN; i++) begin
            cyc(1);
            chk("R3 core_rst high", core_rst, 1'b1);
            chk("R5 quiet in reset", mismatch, 1'b0);
            chk("R4 ds held", ds, 1'b1);
        end
        cyc(1);
        chk("R3 core_rst low after pulse", core_rst, 1'b0);
        rx_half = 50;
        cyc(245);
        chk("R5 mismatch waits one window", mismatch, 1'b0);
        cyc(15);
        chk("R5 mismatch after window", mismatch, 1'b1);
        chk("R6 no isolate with iso_en low", isolate, 1'b0);
        iso_en = 1'b1;
        cyc(1);
        chk("R6 isolate follows iso_en", isolate, 1'b1);
        cyc(139);
        chk("R2 ds held after one slow window", ds, 1'b1);
        cyc(120);
        chk("R2 slow ds after two windows", ds, 1'b0);
        chk("R5 mismatch cleared", mismatch, 1'b0);
        chk("R6 isolate cleared with mismatch", isolate, 1'b0);
    endtask

    // R8: stopped clock leaves ds unchanged
    task automatic t_no_clock();
        rx_half = 0;
        cyc(3 * WIN + 20);
        chk("R8 ds kept with no clock", ds, 1'b0);
        chk("R8 no mismatch", mismatch, 1'b0);
    endtask

    // R1/R5/R6: fast clock against slow select, then select corrected
    task automatic t_fast_mismatch();
        rx_half = 20;
        cyc(3 * WIN + 20);
        chk("R1 fast ds again", ds, 1'b1);
        chk("R5 mismatch fast vs slow sel", mismatch, 1'b1);
        chk("R6 isolate with iso_en", isolate, 1'b1);
        iso_en = 1'b0;
        cyc(1);
        chk("R6 isolate drops with iso_en", isolate, 1'b0);
        chk("R6 mismatch still reported", mismatch, 1'b1);
        iso_en = 1'b1;
        speed_sel = 1'b1;
        cyc(1);
        chk("R3 core_rst on second change", core_rst, 1'b1);
        chk("R5 quiet in reset 2", mismatch, 1'b0);
        cyc(RSTN + WIN + 20);
        chk("R5 no mismatch after correction", mismatch, 1'b0);
        chk("R6 no isolate after correction", isolate, 1'b0);
        chk("R4 ds kept over reset", ds, 1'b1);
    endtask

    initial begin
        t_reset();
        t_fast_lock();
        t_sel_change();
        t_no_clock();
        t_fast_mismatch();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk_ref);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule